// File: doc/BRIEF.md
# Quadrant-Mapped Phase Error Lookup

This block turns a signed 6-bit in-phase sample and a signed 6-bit quadrature sample into a single phase-error bit. The bit is read from a writable table of 4096 one-bit entries. The table is stored as 256 words of 16 bits, and software loads it through a simple register bus. The table is write-only. A host read of any table address returns zero.

An optional fold mode makes use of quadrant symmetry in the constellation. Before the lookup, the sample pair is folded into the first quadrant. After the lookup, the result bit is inverted when the original pair lay in a quadrant with mixed signs. Only a quarter of the table is then needed. The registered error bit is the block's single result: it drives the external pin and also feeds the loop filter. A valid strobe travels alongside it with one cycle of latency.

Top module: `phase_err_lut`

## Requirements
- R1: While reset is held and after it is released, `err_valid_o` and `err_o` are 0 and the fold mode is disabled.
- R2: The lookup index is {I,Q}, with I in bits 11:6 and Q in bits 5:0. Index bits 11:4 select the table word. Index bits 3:0 select the bit within that word, where bit 0 is the word's least significant bit.
- R3: A host write to address 256+w (address bits 9:8 = 01) loads table word w from `reg_wdata_i`, where w is in 0..255.
- R4: A read at any address from 256 to 511 returns 0 on `reg_rdata_o`.
- R5: Address 0 is the control register, and its bit 0 enables fold mode. A read of address 0 returns that bit in bit 0 and zeros elsewhere. Writes to addresses 1–255 and 512–1023 change nothing. Reads of those addresses return 0.
- R6: With fold mode enabled, a component whose sign bit (bit 5) is 1 is replaced by its bitwise complement before the lookup. A component whose sign bit is 0 is used unchanged.
- R7: With fold mode enabled, the looked-up bit is inverted when exactly one of the original I and Q sign bits is 1. With fold mode disabled, no fold and no inversion take place.
- R8: A sample with `smp_valid_i` high at a clock edge produces `err_valid_o` high and its `err_o` after that edge. When `smp_valid_i` is low, `err_valid_o` drops and `err_o` holds its value.
- R9: A table write and a lookup at the same clock edge: the lookup sees the word's previous content, and the next lookup sees the new content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Host write strobe |
| reg_addr_i | input | 10 | Host address |
| reg_wdata_i | input | 16 | Host write data |
| reg_rdata_o | output | 16 | Host read data (combinational from address) |
| smp_valid_i | input | 1 | Sample pair valid |
| smp_i_i | input | 6 | In-phase sample, two's complement |
| smp_q_i | input | 6 | Quadrature sample, two's complement |
| err_valid_o | output | 1 | Phase error valid, one cycle after the sample |
| err_o | output | 1 | Phase error bit, to the pin and the loop filter |

## Verification
A wrong table word, or a wrong bit-select inside a word, appears as a wrong `err_o` on the first lookup whose index lands on that entry, one cycle after the sample. A stuck or wrong fold-enable bit shows up in two ways. Reads of the control register return the wrong value at once. Lookups in the three quadrants that are not the first also give inverted or mis-addressed bits. The bench fills the whole table with random words, sweeps random samples in both modes, and drives the extreme codes -32, -1, 0 and 31. It also writes the table and looks it up on the same edge.

// File: rtl/phase_lut_pkg.sv
package phase_lut_pkg;
  parameter int unsigned SMP_W  = 6;
  parameter int unsigned WORD_W = 16;
  localparam int unsigned IDX_W   = 2 * SMP_W;
  localparam int unsigned BSEL_W  = $clog2(WORD_W);
  localparam int unsigned WSEL_W  = IDX_W - BSEL_W;
  localparam int unsigned DEPTH   = 1 << WSEL_W;
  localparam int unsigned ADDR_W  = WSEL_W + 2;
  localparam logic [1:0]  TBL_SEG = 2'b01;
endpackage

// File: rtl/phase_lut_ctrl.sv
module phase_lut_ctrl
  import phase_lut_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wbit_i,
  output logic              qmap_en_o,
  output logic [WORD_W-1:0] rdata_o
);
  logic sel_ctrl;
  assign sel_ctrl = (addr_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              qmap_en_o <= 1'b0;
    else if (we_i && sel_ctrl) qmap_en_o <= wbit_i;
  end

  // table range and holes read as zero
  always_comb begin
    rdata_o = '0;
    if (sel_ctrl) rdata_o[0] = qmap_en_o;
  end
endmodule

// File: rtl/phase_lut_fold.sv
module phase_lut_fold
  import phase_lut_pkg::*;
(
  input  logic             en_i,
  input  logic [SMP_W-1:0] i_i,
  input  logic [SMP_W-1:0] q_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             inv_o
);
  logic [1:0][SMP_W-1:0] comp_in, comp_out;
  assign comp_in[1] = i_i;
  assign comp_in[0] = q_i;

  for (genvar c = 0; c < 2; c++) begin : g_comp
    assign comp_out[c] = (en_i && comp_in[c][SMP_W-1]) ? ~comp_in[c] : comp_in[c];
  end

  assign idx_o = {comp_out[1], comp_out[0]};
  assign inv_o = en_i & (i_i[SMP_W-1] ^ q_i[SMP_W-1]);
endmodule

// File: rtl/phase_lut_table.sv
module phase_lut_table
  import phase_lut_pkg::*;
(
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [WSEL_W-1:0] waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  ridx_i,
  output logic              rbit_o
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] rword;

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rword  = mem[ridx_i[IDX_W-1:BSEL_W]];
  assign rbit_o = rword[ridx_i[BSEL_W-1:0]];
endmodule

// File: rtl/phase_err_lut.sv
module phase_err_lut
  import phase_lut_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  output logic [WORD_W-1:0] reg_rdata_o,
  input  logic              smp_valid_i,
  input  logic [SMP_W-1:0]  smp_i_i,
  input  logic [SMP_W-1:0]  smp_q_i,
  output logic              err_valid_o,
  output logic              err_o
);
  logic             qmap_en;
  logic [IDX_W-1:0] idx;
  logic             inv, rbit, tbl_we;

  assign tbl_we = reg_we_i && (reg_addr_i[ADDR_W-1 -: 2] == TBL_SEG);

  phase_lut_ctrl u_ctrl (
    .clk_i, .rst_ni,
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wbit_i    (reg_wdata_i[0]),
    .qmap_en_o (qmap_en),
    .rdata_o   (reg_rdata_o)
  );

  phase_lut_fold u_fold (
    .en_i  (qmap_en),
    .i_i   (smp_i_i),
    .q_i   (smp_q_i),
    .idx_o (idx),
    .inv_o (inv)
  );

  phase_lut_table u_tbl (
    .clk_i,
    .we_i    (tbl_we),
    .waddr_i (reg_addr_i[WSEL_W-1:0]),
    .wdata_i (reg_wdata_i),
    .ridx_i  (idx),
    .rbit_o  (rbit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_valid_o <= 1'b0;
      err_o       <= 1'b0;
    end else begin
      err_valid_o <= smp_valid_i;
      if (smp_valid_i) err_o <= rbit ^ inv;
    end
  end
endmodule

// File: rtl/phase_err_lut_chk.sv
module phase_err_lut_chk
  import phase_lut_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic              wbit,
  input logic [WORD_W-1:0] reg_rdata_o,
  input logic              smp_valid_i,
  input logic              err_valid_o,
  input logic              err_o,
  input logic              qmap_en
);
  p_rst_state_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!err_valid_o && !err_o && !qmap_en));

  p_tbl_read_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i[ADDR_W-1 -: 2] == TBL_SEG) |-> (reg_rdata_o == '0));

  p_ctrl_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == '0) |=> (qmap_en == $past(wbit)));

  p_ctrl_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_i && reg_addr_i == '0) |=> $stable(qmap_en));

  p_vld_follow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_i |=> err_valid_o);

  p_vld_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_valid_i |=> !err_valid_o);

  p_err_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_valid_i |=> $stable(err_o));
endmodule

bind phase_err_lut phase_err_lut_chk u_chk (
  .clk_i, .rst_ni, .reg_we_i, .reg_addr_i,
  .wbit (reg_wdata_i[0]),
  .reg_rdata_o, .smp_valid_i, .err_valid_o, .err_o, .qmap_en
);

// File: tb/sim_phase_err_lut.sv
`timescale 1ns/1ps
module sim_phase_err_lut;
  logic        clk = 0, rst_ni = 0;
  logic        reg_we = 0;
  logic [9:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic        smp_valid = 0;
  logic [5:0]  smp_i = '0, smp_q = '0;
  logic        err_valid, err;

  int n_chk = 0, n_fail = 0;
  logic [15:0] tbl [256];
  logic        qm = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  phase_err_lut u0 (
    .clk_i(clk), .rst_ni, .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .smp_valid_i(smp_valid), .smp_i_i(smp_i), .smp_q_i(smp_q),
    .err_valid_o(err_valid), .err_o(err)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic exp_err(logic [5:0] i, logic [5:0] q, logic m);
    logic [5:0] fi, fq;
    logic [11:0] idx;
    logic b;
    fi = (m && i[5]) ? ~i : i;
    fq = (m && q[5]) ? ~q : q;
    idx = {fi, fq};
    b = tbl[idx[11:4]][idx[3:0]];
    return m ? (b ^ i[5] ^ q[5]) : b;
  endfunction

  task automatic host_wr(logic [9:0] a, logic [15:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
    if (a[9:8] == 2'b01) tbl[a[7:0]] = d;
    if (a == 0) qm = d[0];
  endtask

  task automatic lookup(logic [5:0] i, logic [5:0] q, string req);
    @(negedge clk);
    smp_valid = 1; smp_i = i; smp_q = q;
    @(negedge clk);
    smp_valid = 0;
    check(req, {15'b0, err_valid}, 16'd1);
    check(req, {15'b0, err}, {15'b0, exp_err(i, q, qm)});
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic held;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check("R1 valid in reset", {15'b0, err_valid}, 16'd0);
    rst_ni = 1;
    @(negedge clk);
    check("R1 valid after reset", {15'b0, err_valid}, 16'd0);
    check("R1 err after reset", {15'b0, err}, 16'd0);
    reg_addr = 0; #1;
    check("R1 fold off", reg_rdata, 16'd0);

    // R3: fill table
    for (int w = 0; w < 256; w++) host_wr(10'(256 + w), 16'($urandom));

    // R4: reads of table range
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      reg_addr = 10'(256 + ($urandom % 256)); #1;
      check("R4 table read zero", reg_rdata, 16'd0);
    end

    // R2 directed bit select on word 0x25
    host_wr(10'(256 + 8'h25), 16'h8001);
    lookup(6'b001001, 6'b010000, "R2 bit0 of word");
    lookup(6'b001001, 6'b011111, "R2 bit15 of word");
    lookup(6'b001001, 6'b010101, "R2 middle bit");

    // R2/R3 random lookups, fold off
    for (int k = 0; k < 200; k++)
      lookup(6'($urandom), 6'($urandom), "R2 R3 random off");

    // R5 control register
    host_wr(10'd0, 16'hfff1);
    reg_addr = 0; #1;
    check("R5 ctrl read", reg_rdata, 16'd1);
    host_wr(10'd7, 16'h0000);
    host_wr(10'd600, 16'h0000);
    reg_addr = 0; #1;
    check("R5 writes to holes ignored", reg_rdata, 16'd1);
    reg_addr = 10'd7; #1;
    check("R5 hole read zero", reg_rdata, 16'd0);
    reg_addr = 10'd600; #1;
    check("R5 upper hole read zero", reg_rdata, 16'd0);
    // word 600&255=88 must be untouched
    for (int b = 0; b < 16; b++)
      lookup(6'(88 >> 2), 6'({2'(88 & 3), 4'(b)}), "R5 table untouched");

    // R6 R7 fold on: corners
    lookup(6'b100000, 6'b000000, "R6 R7 I=-32 Q=0");
    lookup(6'b111111, 6'b111111, "R6 R7 I=-1 Q=-1");
    lookup(6'b011111, 6'b100000, "R6 R7 I=31 Q=-32");
    lookup(6'b000000, 6'b111111, "R6 R7 I=0 Q=-1");
    lookup(6'b011111, 6'b011111, "R6 first quadrant");
    for (int k = 0; k < 200; k++)
      lookup(6'($urandom), 6'($urandom), "R6 R7 random on");

    // R7: fold off again
    host_wr(10'd0, 16'h0000);
    lookup(6'b100000, 6'b000001, "R7 off no invert");
    for (int k = 0; k < 50; k++)
      lookup(6'($urandom), 6'($urandom), "R7 random off");

    // R8 hold when no valid
    lookup(6'd3, 6'd9, "R8 setup");
    held = err;
    @(negedge clk);
    smp_i = 6'($urandom); smp_q = 6'($urandom);
    @(negedge clk);
    check("R8 valid drops", {15'b0, err_valid}, 16'd0);
    check("R8 err holds", {15'b0, err}, {15'b0, held});

    // R9 same-edge write and lookup on word 0x13
    host_wr(10'(256 + 8'h13), 16'h0000);
    @(negedge clk);
    reg_we = 1; reg_addr = 10'(256 + 8'h13); reg_wdata = 16'hffff;
    smp_valid = 1; smp_i = 6'b000100; smp_q = 6'b110010;
    @(negedge clk);
    reg_we = 0; smp_valid = 0;
    check("R9 old content seen", {15'b0, err}, 16'd0);
    tbl[8'h13] = 16'hffff;
    lookup(6'b000100, 6'b110010, "R9 new content seen");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule